// File: doc/BRIEF.md
# Self-Correcting Triplicated Storage Register

This block is an N-bit register built to tolerate single-event upsets. Each bit is stored in three independent copies. Each copy is a master stage followed by a stored slave stage. A two-out-of-three vote over the stored copies drives the output.

Every copy has its own voter at the master stage, which chooses the value the copy stores next. That value is the new data when a load is requested. Otherwise it is the current voted output, fed back. Because of this, a copy that has been flipped is rewritten on the next clock edge, whether or not new data arrives, and a second upset cannot combine with an earlier one that was never repaired.

A per-bit disagreement vector and a combined flag show when the stored copies differ. A fault-injection port lets a bench invert a chosen set of copies of one bit, either in the stored slave stage or on the master-stage value for one edge.

Top module: `tmr_selfheal_reg`

## Requirements
- R1: While `rst` is high at a rising clock edge, every copy of every bit is cleared to 0, whatever `load_en` and the fault-injection inputs do. After that edge, `q_out` is 0 and `mismatch_any` is low.
- R2: When `load_en` is high at an edge with no injection, `q_out` equals the `d_in` sampled at that edge from the next cycle on.
- R3: When `load_en` and `fi_en` are both low at an edge, `q_out` keeps its value, whatever `d_in` carries.
- R4: Each bit of `q_out` is the two-out-of-three majority of that bit's three stored copies.
- R5: `mismatch_bits[i]` is high exactly when the three stored copies of bit i are not all equal. `mismatch_any` is the OR of all the bits of `mismatch_bits`.
- R6: After any edge with `fi_en` low and `rst` low, all three copies of every bit hold the same value, so `mismatch_any` is low.
- R7: Fault-injection encoding: when `fi_en` is high, bit k of `fi_copy` (k = 0..2) selects copy k, and `fi_bit` selects the bit position. With `fi_master` = 0, the selected copies store the inverse of their normal next value at that edge. With `fi_master` = 1, the master-stage value of the selected copies is inverted before the master vote.
- R8: A stored-stage injection into exactly one copy leaves `q_out` unchanged. It raises `mismatch_bits` at the injected position only, for exactly one cycle, and the copy is repaired at the following edge.
- R9: A master-stage injection into exactly one copy is absorbed by the master vote: no stored copy changes, `mismatch_any` stays low and `q_out` is unchanged.
- R10: When `load_en` and a single-copy stored-stage injection occur at the same edge, `q_out` shows the loaded `d_in`, the injected bit is flagged for one cycle, and the next edge repairs it.
- R11: Two or three copies of the same bit corrupted at one edge lie outside the guaranteed protection, and `q_out` follows the corrupted majority. A two-copy stored fault flags that bit for one cycle. At the following edge the corrupted value is written into all copies and is kept, with `mismatch_any` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears all copies |
| load_en | input | 1 | Write `d_in` into all three copies at the next edge |
| d_in | input | WIDTH | Data to store |
| fi_en | input | 1 | Enable fault injection for this edge |
| fi_copy | input | 3 | Copy-select mask; bit k picks copy k |
| fi_bit | input | IDX_W | Bit position to corrupt |
| fi_master | input | 1 | 0: corrupt the stored slave stage, 1: corrupt the master-stage value |
| q_out | output | WIDTH | Voted register value |
| mismatch_bits | output | WIDTH | Per-bit flag: stored copies disagree |
| mismatch_any | output | 1 | OR of `mismatch_bits` |

## Verification
The hardest condition to reach from the ports is a stored copy that disagrees with its two partners. The repair loop erases any such disagreement at the very next edge, so in normal operation it lasts for only one cycle. The bench uses the injection port to flip chosen copies for one edge and samples the one cycle in which the fault exists. It sweeps every stored value, bit position and copy mask of a four-bit instance and checks both the masked output and the repair that follows. It also aims injections at the master stage and injects in the same edge as a load, to show that the master vote absorbs a lone fault and that a load and a repair can share an edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int NCOPY = 3;

  // Two-out-of-three majority of single bits.
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // High when three bits are not all equal.
  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (a ^ c);
  endfunction

endpackage

// File: rtl/tmr_voter.sv
module tmr_voter #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] c_i,
  output logic [WIDTH-1:0] y_o,
  output logic [WIDTH-1:0] split_o
);
  import tmr_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y_o[i]     = maj3(a_i[i], b_i[i], c_i[i]);
    assign split_o[i] = split3(a_i[i], b_i[i], c_i[i]);
  end

  // R4: whenever two inputs agree, the output follows them
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      if (a_i[i] == b_i[i]) begin
        pair_follow_chk: assert (y_o[i] == a_i[i]);
      end
    end
  end
endmodule

// File: rtl/tmr_copy.sv
module tmr_copy #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] mst_a_i,
  input  logic [WIDTH-1:0] mst_b_i,
  input  logic [WIDTH-1:0] mst_c_i,
  input  logic [WIDTH-1:0] slv_flip_i,
  output logic [WIDTH-1:0] slv_q_o
);
  logic [WIDTH-1:0] mst_vote;
  logic [WIDTH-1:0] mst_split;
  logic [WIDTH-1:0] slv_next;

  // Private master-stage voter for this copy
  tmr_voter #(.WIDTH(WIDTH)) i_mst_vote (
    .a_i    (mst_a_i),
    .b_i    (mst_b_i),
    .c_i    (mst_c_i),
    .y_o    (mst_vote),
    .split_o(mst_split)
  );

  assign slv_next = mst_vote ^ slv_flip_i;

  always_ff @(posedge clk) begin
    if (rst) slv_q_o <= '0;
    else     slv_q_o <= slv_next;
  end

  // R1
  copy_reset_chk: assert property (@(posedge clk) rst |=> slv_q_o == '0);

  // R9: a lone master-stage disagreement never reaches this copy
  copy_absorb_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(mst_split) == 1 && slv_flip_i == '0 &&
     ((mst_a_i == mst_b_i) || (mst_a_i == mst_c_i) || (mst_b_i == mst_c_i)))
    |=> slv_q_o == $past(mst_a_i & mst_b_i | mst_a_i & mst_c_i | mst_b_i & mst_c_i));
endmodule

// File: rtl/tmr_selfheal_reg.sv
module tmr_selfheal_reg #(
  parameter int WIDTH = 8,
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d_in,
  input  logic             fi_en,
  input  logic [2:0]       fi_copy,
  input  logic [IDX_W-1:0] fi_bit,
  input  logic             fi_master,
  output logic [WIDTH-1:0] q_out,
  output logic [WIDTH-1:0] mismatch_bits,
  output logic             mismatch_any
);
  import tmr_pkg::*;

  logic [NCOPY-1:0][WIDTH-1:0] mst_val;
  logic [NCOPY-1:0][WIDTH-1:0] mst_flip;
  logic [NCOPY-1:0][WIDTH-1:0] slv_flip;
  logic [NCOPY-1:0][WIDTH-1:0] slv_q;
  logic [WIDTH-1:0]            slv_vote;
  logic [WIDTH-1:0]            slv_split;

  // Named events for the assertions
  logic heal_edge, load_edge, hold_edge, lone_slv_hit, lone_mst_hit;
  assign heal_edge    = !rst && !fi_en;
  assign load_edge    = heal_edge && load_en;
  assign hold_edge    = heal_edge && !load_en;
  assign lone_slv_hit = fi_en && !fi_master && $countones(fi_copy) == 1;
  assign lone_mst_hit = fi_en &&  fi_master && $countones(fi_copy) == 1;

  // Injection masks per copy
  always_comb begin
    mst_flip = '0;
    slv_flip = '0;
    for (int k = 0; k < NCOPY; k++) begin
      if (fi_en && fi_copy[k]) begin
        if (fi_master) mst_flip[k][fi_bit] = 1'b1;
        else           slv_flip[k][fi_bit] = 1'b1;
      end
    end
  end

  // Master stage: new data, or the voted value fed back for repair
  always_comb begin
    for (int k = 0; k < NCOPY; k++) begin
      mst_val[k] = (load_en ? d_in : slv_vote) ^ mst_flip[k];
    end
  end

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    tmr_copy #(.WIDTH(WIDTH)) i_copy (
      .clk       (clk),
      .rst       (rst),
      .mst_a_i   (mst_val[0]),
      .mst_b_i   (mst_val[1]),
      .mst_c_i   (mst_val[2]),
      .slv_flip_i(slv_flip[k]),
      .slv_q_o   (slv_q[k])
    );
  end

  // Slave-stage vote drives the output
  tmr_voter #(.WIDTH(WIDTH)) i_slv_vote (
    .a_i    (slv_q[0]),
    .b_i    (slv_q[1]),
    .c_i    (slv_q[2]),
    .y_o    (slv_vote),
    .split_o(slv_split)
  );

  assign q_out         = slv_vote;
  assign mismatch_bits = slv_split;
  assign mismatch_any  = |slv_split;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (q_out == '0 && !mismatch_any));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load_edge |=> q_out == $past(d_in));

  // R3
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    hold_edge |=> $stable(q_out));

  // R6
  heal_all_chk: assert property (@(posedge clk) disable iff (rst)
    heal_edge |=> !mismatch_any);

  // R8
  lone_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (lone_slv_hit && !load_en) |=> ($stable(q_out) && $onehot(mismatch_bits)));

  // R9
  master_absorb_chk: assert property (@(posedge clk) disable iff (rst)
    (lone_mst_hit && !load_en) |=> ($stable(q_out) && !mismatch_any));

  // R10
  load_and_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (lone_slv_hit && load_en) |=> q_out == $past(d_in));
endmodule

// File: tb/test_tmr_selfheal_reg.sv
module test_tmr_selfheal_reg;
  localparam int W  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          load_en;
  logic [W-1:0]  d_in;
  logic          fi_en;
  logic [2:0]    fi_copy;
  logic [IW-1:0] fi_bit;
  logic          fi_master;
  logic [W-1:0]  q_out;
  logic [W-1:0]  mismatch_bits;
  logic          mismatch_any;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tmr_selfheal_reg #(.WIDTH(W)) i_tmr_selfheal_reg (
    .clk(clk), .rst(rst), .load_en(load_en), .d_in(d_in),
    .fi_en(fi_en), .fi_copy(fi_copy), .fi_bit(fi_bit), .fi_master(fi_master),
    .q_out(q_out), .mismatch_bits(mismatch_bits), .mismatch_any(mismatch_any)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    load_en = 0; fi_en = 0; fi_copy = 0; fi_master = 0; fi_bit = 0;
  endtask

  task automatic do_load(input logic [W-1:0] v);
    d_in = v; load_en = 1;
    tick();
    quiet();
    check("R2 load q_out", q_out, v);
    check("R2 load mismatch", {mismatch_any, mismatch_bits}, 0);
  endtask

  task automatic hit(input int b, input logic [2:0] mask, input logic mst, input logic ld);
    fi_en = 1; fi_bit = IW'(b); fi_copy = mask; fi_master = mst; load_en = ld;
    tick();
    quiet();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    if (!done) $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    quiet();
    d_in = 0;
    rst = 1;
    tick();
    fi_en = 1; fi_copy = 3'b111; load_en = 1; d_in = 4'hF;
    tick();
    quiet();
    rst = 0;
    check("R1 reset q_out", q_out, 0);
    check("R1 reset mismatch", {mismatch_any, mismatch_bits}, 0);

    for (int v = 0; v < 16; v++) begin
      do_load(W'(v));
      d_in = ~W'(v);
      tick();
      tick();
      check("R3 hold q_out", q_out, v);
      for (int b = 0; b < W; b++) begin
        for (int k = 0; k < 3; k++) begin
          // R7 R8: one stored copy flipped
          hit(b, 3'(1 << k), 1'b0, 1'b0);
          check("R4 R8 lone stored hit q_out", q_out, v);
          check("R5 R8 flagged bit", mismatch_bits, 1 << b);
          check("R5 mismatch_any", mismatch_any, 1);
          tick();
          check("R6 R8 repaired q_out", q_out, v);
          check("R6 R8 repaired mismatch", {mismatch_any, mismatch_bits}, 0);
          // R9: one master-stage value flipped
          hit(b, 3'(1 << k), 1'b1, 1'b0);
          check("R9 master hit q_out", q_out, v);
          check("R9 master hit mismatch", {mismatch_any, mismatch_bits}, 0);
        end
      end
    end

    for (int v = 0; v < 16; v++) begin
      for (int b = 0; b < W; b++) begin
        logic [W-1:0] bad;
        bad = W'(v) ^ W'(1 << b);
        for (int p = 0; p < 3; p++) begin
          logic [2:0] pair;
          pair = 3'b111 ^ 3'(1 << p);
          do_load(W'(v));
          hit(b, pair, 1'b0, 1'b0);
          check("R4 R11 double stored q_out", q_out, bad);
          check("R5 R11 double stored flag", mismatch_bits, 1 << b);
          tick();
          check("R11 corrupt kept q_out", q_out, bad);
          check("R11 corrupt kept mismatch", mismatch_any, 0);
          do_load(W'(v));
          hit(b, pair, 1'b1, 1'b0);
          check("R11 double master q_out", q_out, bad);
          check("R11 double master mismatch", mismatch_any, 0);
        end
        do_load(W'(v));
        hit(b, 3'b111, 1'b0, 1'b0);
        check("R11 triple stored q_out", q_out, bad);
        check("R11 triple stored mismatch", mismatch_any, 0);
      end
    end

    for (int v = 0; v < 16; v++) begin
      logic [W-1:0] w;
      w = W'(v * 7 + 5);
      for (int b = 0; b < W; b++) begin
        for (int k = 0; k < 3; k++) begin
          do_load(W'(v));
          d_in = w;
          hit(b, 3'(1 << k), 1'b0, 1'b1);
          check("R10 load+hit q_out", q_out, w);
          check("R10 load+hit flag", mismatch_bits, 1 << b);
          tick();
          check("R10 load+hit repaired", {mismatch_any, mismatch_bits}, 0);
          check("R10 load+hit kept", q_out, w);
        end
      end
    end

    do_load(4'hF);
    fi_en = 1; fi_copy = 3'b001;
    rst = 1;
    tick();
    rst = 0;
    quiet();
    check("R1 mid-run reset q_out", q_out, 0);
    check("R1 mid-run reset mismatch", {mismatch_any, mismatch_bits}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule